// File: doc/BRIEF.md
# Quad-Word-Safe System Bus Arbiter

This block decides which of several masters owns a shared system bus. Master 0 is normally the processor, which fills its cache one quad-word at a time. A quad-word is four 32-bit words, which is also one eight-half-word burst of the memory behind the bus. Ownership may move only at a safe point. A safe point is a cycle in which the bus is idle, or a cycle in which the current transfer addresses the last word of an aligned quad-word, meaning word-select bits [3:2] equal 2'b11. Because of this rule, a line fill and the memory burst behind it are never split between two owners.

At each safe point a fixed priority picks the next owner, and master 0 has the highest priority. When no master requests, the bus goes to a default master, so it always has an owner. The new grant takes effect on the clock edge that ends the safe cycle. The video refresh path reaches memory through its own route and is not seen by this block.

Top module: `burst_bound_arb`

## Requirements
- R1: During and right after reset, exactly the default master (parameter DEFAULT_MASTER, 0 by default) holds the grant, and `owner` equals its index.
- R2: Exactly one bit of `gnt` is 1 in every cycle.
- R3: `owner` is always the binary index of the single set bit of `gnt`.
- R4: In a cycle where `bus_active` is 1 and `addr_word` is not 2'b11, the grant in the next cycle is the same as the current grant.
- R5: In a cycle where `bus_active` is 0 and at least one `req` bit is set, the grant in the next cycle goes to the lowest-numbered requesting master.
- R6: In a cycle where `bus_active` is 1 and `addr_word` is 2'b11, the grant in the next cycle goes to the lowest-numbered requesting master, or to the default master if no master requests.
- R7: At a safe point (idle, or `addr_word` equal to 2'b11) with no request set, the grant in the next cycle goes to the default master.
- R8: A master that holds the grant and drops its request in an idle cycle loses the grant at the next edge, even though its quad-word is unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req | input | N_MASTERS | One request line per master; bit 0 has the highest priority |
| bus_active | input | 1 | 1 while a transfer is in progress; 0 when the bus is idle |
| addr_word | input | 2 | Word-select address bits [3:2] of the current transfer |
| gnt | output | N_MASTERS | One-hot grant, registered |
| owner | output | IDX_W | Index of the current owner, registered |

## Verification
The assertions take `bus_active` and `addr_word` as settled before each rising edge, and they take `req` as a plain level with no handshake. They do not require a master to hold its request for a whole quad-word, because R8 allows a request to drop while the bus is idle. The bench changes every input only on the falling edge, so each sample is stable at the rising edge. The bench first sets an owner with an idle request pattern, then applies every combination of requests, activity and word-select. This covers safe and unsafe cycles from every possible prior owner without leaving the input space that the properties assume.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Width of the word-select field taken from address bits [3:2]
  localparam int unsigned WSEL_W = 2;

  // A transfer at the last word of a quad-word closes it
  function automatic logic last_word(input logic [WSEL_W-1:0] wsel);
    return &wsel;
  endfunction

  // A safe point is any idle cycle or any closing word
  function automatic logic is_safe(input logic active, input logic [WSEL_W-1:0] wsel);
    return !active || last_word(wsel);
  endfunction

endpackage

// File: rtl/bus_arb_safe_pt.sv
module bus_arb_safe_pt
  import bus_arb_pkg::*;
(
  input  logic              bus_active,
  input  logic [WSEL_W-1:0] addr_word,
  output logic              safe_pt,
  output logic              idle_pt,
  output logic              close_pt
);

  always_comb begin
    idle_pt  = !bus_active;
    close_pt = bus_active && last_word(addr_word);
    safe_pt  = is_safe(bus_active, addr_word);
  end

endmodule

// File: rtl/bus_arb_prio_pick.sv
module bus_arb_prio_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned DEF   = 0,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_valid
);

  // higher[i]: some master with a lower index is requesting
  logic [N-1:0] higher;

  assign higher[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_chain
      assign higher[gi] = higher[gi-1] | req[gi-1];
    end
  endgenerate

  logic [N-1:0] win;
  assign win        = req & ~higher;
  assign pick_valid = |req;

  // one-hot of the winner, or of the default master when nobody asks
  always_comb begin
    pick_oh = '0;
    if (pick_valid) pick_oh = win;
    else            pick_oh[DEF] = 1'b1;
  end

  // index found independently of the one-hot vector
  always_comb begin
    pick_idx = IDX_W'(DEF);
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) pick_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/bus_arb_grant_reg.sv
module bus_arb_grant_reg #(
  parameter int unsigned N     = 4,
  parameter int unsigned DEF   = 0,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N-1:0]     next_oh,
  input  logic [IDX_W-1:0] next_idx,
  output logic [N-1:0]     gnt_q,
  output logic [IDX_W-1:0] owner_q
);

  localparam logic [N-1:0] DEF_OH = N'(1) << DEF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q   <= DEF_OH;
      owner_q <= IDX_W'(DEF);
    end else if (load) begin
      gnt_q   <= next_oh;
      owner_q <= next_idx;
    end
  end

endmodule

// File: rtl/burst_bound_arb.sv
module burst_bound_arb
  import bus_arb_pkg::*;
#(
  parameter int unsigned N_MASTERS      = 4,
  parameter int unsigned DEFAULT_MASTER = 0,
  localparam int unsigned IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 bus_active,
  input  logic [1:0]           addr_word,
  output logic [N_MASTERS-1:0] gnt,
  output logic [IDX_W-1:0]     owner
);

  // named internal events, visible to the checker
  logic                 safe_pt;
  logic                 idle_pt;
  logic                 close_pt;
  logic [N_MASTERS-1:0] pick_oh;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_valid;

  bus_arb_safe_pt u_safe (
    .bus_active (bus_active),
    .addr_word  (addr_word),
    .safe_pt    (safe_pt),
    .idle_pt    (idle_pt),
    .close_pt   (close_pt)
  );

  bus_arb_prio_pick #(
    .N     (N_MASTERS),
    .DEF   (DEFAULT_MASTER),
    .IDX_W (IDX_W)
  ) u_pick (
    .req        (req),
    .pick_oh    (pick_oh),
    .pick_idx   (pick_idx),
    .pick_valid (pick_valid)
  );

  bus_arb_grant_reg #(
    .N     (N_MASTERS),
    .DEF   (DEFAULT_MASTER),
    .IDX_W (IDX_W)
  ) u_greg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (safe_pt),
    .next_oh  (pick_oh),
    .next_idx (pick_idx),
    .gnt_q    (gnt),
    .owner_q  (owner)
  );

endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned DEF   = 0,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req,
  input logic             bus_active,
  input logic [1:0]       addr_word,
  input logic [N-1:0]     gnt,
  input logic [IDX_W-1:0] owner,
  input logic             safe_pt,
  input logic             idle_pt,
  input logic             close_pt
);

  logic [N-1:0] low_req;
  assign low_req = req & (~req + N'(1));

  a_r1_reset_default: assert property (@(posedge clk)
    !rst_n |=> (owner == IDX_W'(DEF)) || !rst_n);

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == 1);

  a_r3_owner_match: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[owner] == 1'b1);

  a_r4_hold_mid_quad: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && addr_word != 2'b11) |=> $stable(gnt));

  a_r5_idle_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_pt && req != '0) |=> gnt == $past(low_req));

  a_r6_close_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (close_pt && req != '0) |=> gnt == $past(low_req));

  a_r7_default_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_pt && req == '0) |=> owner == IDX_W'(DEF));

  a_r8_drop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_active && (gnt & req) == '0 && req != '0) |=> !$stable(gnt) || (gnt == $past(low_req)));

endmodule

bind burst_bound_arb bus_arb_chk #(
  .N     (N_MASTERS),
  .DEF   (DEFAULT_MASTER),
  .IDX_W (IDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .bus_active (bus_active),
  .addr_word  (addr_word),
  .gnt        (gnt),
  .owner      (owner),
  .safe_pt    (safe_pt),
  .idle_pt    (idle_pt),
  .close_pt   (close_pt)
);

// File: tb/burst_bound_arb_tb.sv
module burst_bound_arb_tb_top;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         bus_active = 1'b0;
  logic [1:0]   addr_word = 2'b00;
  logic [N-1:0] gnt;
  logic [1:0]   owner;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  burst_bound_arb #(.N_MASTERS(N), .DEFAULT_MASTER(0)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .bus_active (bus_active),
    .addr_word  (addr_word),
    .gnt        (gnt),
    .owner      (owner)
  );

  // lowest set index, or 0 (default master) when nothing is set
  function automatic int pick(input int r);
    for (int i = 0; i < N; i++) if ((r >> i) & 1) return i;
    return 0;
  endfunction

  task automatic check(input string tag, input int exp_idx);
    n_run++;
    if (gnt !== (N'(1) << exp_idx) || owner !== 2'(exp_idx)) begin
      n_fail++;
      $display("FAIL %s: gnt=%b owner=%0d expected gnt=%b owner=%0d",
               tag, gnt, owner, N'(1) << exp_idx, exp_idx);
    end
    n_run++;
    if ($countones(gnt) != 1) begin
      n_fail++;
      $display("FAIL R2: gnt=%b has %0d bits set, expected 1", gnt, $countones(gnt));
    end
  endtask

  // drive at the falling edge, then wait one full cycle
  task automatic step(input int r, input logic a, input logic [1:0] w);
    req        = N'(r);
    bus_active = a;
    addr_word  = w;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 0);

    // R8 directed: master 2 takes the bus, then drops its request while idle
    step(4, 1'b0, 2'b00);
    check("R5 take", 2);
    step(4, 1'b1, 2'b01);
    check("R4 hold", 2);
    step(0, 1'b0, 2'b01);
    check("R8 drop to default", 0);
    step(4, 1'b0, 2'b00);
    step(8, 1'b0, 2'b10);
    check("R8 drop to other", 3);

    // sweep: set an owner while idle, then apply every input combination
    for (int s = 0; s < 16; s++) begin
      for (int r = 0; r < 16; r++) begin
        for (int a = 0; a < 2; a++) begin
          for (int w = 0; w < 4; w++) begin
            int exp_idx;
            string tag;
            step(s, 1'b0, 2'b00);
            check("R5 setup", pick(s));
            step(r, a[0], 2'(w));
            if (a == 1 && w != 3) begin
              exp_idx = pick(s);
              tag = "R4";
            end else if (r == 0) begin
              exp_idx = 0;
              tag = "R7";
            end else if (a == 0) begin
              exp_idx = pick(r);
              tag = ((s >> pick(s)) & 1) && !((r >> pick(s)) & 1) ? "R8" : "R5";
            end else begin
              exp_idx = pick(r);
              tag = "R6";
            end
            check(tag, exp_idx);
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule